// File: doc/BRIEF.md
# Gated General-Purpose Output Port with Per-Pin Change Strobes

This block drives a 24-pin general-purpose output port from a byte-wide register bus. Software keeps two 24-bit vectors, a data vector and an output-enable vector. Each is written one byte lane at a time. A pin shows the AND of its data bit and its enable bit, so a pin with its enable cleared is seen as low whatever its data bit holds.

Each pin has a change strobe, a one-cycle pulse. It fires in the cycle when that pin's visible level takes a new value, so a consumer can react to edges without comparing levels itself. Byte lanes that belong to the input side of the port (status, interrupt mask, edge-detect enable, level invert) and a 16-bit port enable word are kept as plain read/write storage. They have no effect on the pins.

Reads are combinational from the address. A read has no side effects. The lane count parameter may be set from 1 to 4.

Top module: `gpo_notify_port`

## Requirements
- R1: While reset (`rst_n` low) is asserted, and after it is released, every stored byte, `pin_level` and `pin_chg` are zero. No strobe fires as a result of reset.
- R2: A write to 0x78, 0x79 or 0x7a replaces data bits 7:0, 15:8 or 23:16 respectively and leaves the other lanes unchanged. Reading the same address returns the stored byte.
- R3: A write to 0x7c, 0x7d or 0x7e replaces enable bits 7:0, 15:8 or 23:16 respectively, with the same lane isolation. Reading the same address returns the stored byte.
- R4: `pin_level` equals data AND enable as held after the previous clock edge. A write at edge k is therefore visible on the pins after edge k+1.
- R5: `pin_chg[i]` is high for exactly one cycle, in the cycle where `pin_level[i]` differs from its value in the previous cycle. `pin_level` already carries the new level in that cycle.
- R6: A write that leaves a pin's gated value unchanged raises no strobe and leaves that pin's level alone. Examples are rewriting the same byte, or changing a data bit whose enable is 0.
- R7: The bytes at 0x60-0x61, 0x64-0x66, 0x68-0x6a, 0x6c-0x6e and 0x70-0x72 are read/write storage that reads back what was written. Writing them never changes `pin_level` or `pin_chg`.
- R8: Any other address, for example 0x7b, 0x7f or 0x00, reads as 0x00. A write to such an address changes no stored byte and no pin.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Write strobe; the byte is stored at the rising edge |
| bus_addr | input | 8 | Byte address for reads and writes |
| bus_wdata | input | 8 | Write data byte |
| bus_rdata | output | 8 | Read data for `bus_addr`, combinational |
| pin_level | output | 24 | Gated output level, data AND enable |
| pin_chg | output | 24 | One-cycle change strobe per pin |

## Verification
The main function is tried with three input patterns:
- A hand-ordered sequence sets data while the enables are off, then opens the enables lane by lane, then closes them. This separates gating from plain data storage and shows both rising and falling strobes.
- Repeated writes of the same byte, and data changes under a zero enable, show that strobes come only from real changes of the gated value and not from write activity.
- A long pseudo-random stream of writes spread over data, enable, storage and unmapped addresses is compared against a behavioural model on every clock. This exposes lane cross-talk, a wrong strobe timing and any leak from the storage bytes onto the pins.

// File: rtl/gpo_pkg.sv
package gpo_pkg;
  localparam int ADDR_W  = 8;
  localparam int BYTE_W  = 8;
  localparam int MAX_LANES = 4;
  localparam int PICK_W  = MAX_LANES * BYTE_W;

  // true when addr falls inside [base, base+count)
  function automatic logic in_window(input logic [ADDR_W-1:0] addr,
                                     input logic [ADDR_W-1:0] base,
                                     input int count);
    int a;
    int b;
    a = int'(addr);
    b = int'(base);
    return (a >= b) && (a < b + count);
  endfunction

  // selects byte lane idx from a zero-extended vector
  function automatic logic [BYTE_W-1:0] pick_byte(input logic [PICK_W-1:0] vec,
                                                  input int idx);
    int k;
    k = idx % MAX_LANES;
    return vec[k*BYTE_W +: BYTE_W];
  endfunction

  // gated level: a pin is high only when both data and enable are high
  function automatic logic [PICK_W-1:0] gate_level(input logic [PICK_W-1:0] data,
                                                   input logic [PICK_W-1:0] en);
    return data & en;
  endfunction
endpackage

// File: rtl/gpo_byte_bank.sv
module gpo_byte_bank
  import gpo_pkg::*;
#(
  parameter int LANES = 3,
  parameter logic [ADDR_W-1:0] BASE = '0
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wr_en,
  input  logic [ADDR_W-1:0]       wr_addr,
  input  logic [BYTE_W-1:0]       wr_byte,
  output logic [LANES*BYTE_W-1:0] vec_q
);
  genvar l;
  generate
    for (l = 0; l < LANES; l++) begin : g_lane
      localparam logic [ADDR_W-1:0] LANE_ADDR = BASE + ADDR_W'(l);
      logic [BYTE_W-1:0] lane_q;
      logic              lane_wr;
      assign lane_wr = wr_en && (wr_addr == LANE_ADDR);
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)       lane_q <= '0;
        else if (lane_wr) lane_q <= wr_byte;
      end
      assign vec_q[l*BYTE_W +: BYTE_W] = lane_q;
    end
  endgenerate
endmodule

// File: rtl/gpo_change_track.sv
module gpo_change_track #(
  parameter int W = 24
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] eff_level,
  output logic [W-1:0] level_q,
  output logic [W-1:0] chg_q
);
  logic [W-1:0] diff;
  assign diff = eff_level ^ level_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      level_q <= '0;
      chg_q   <= '0;
    end else begin
      level_q <= eff_level;
      chg_q   <= diff;
    end
  end
endmodule

// File: rtl/gpo_aux_store.sv
module gpo_aux_store
  import gpo_pkg::*;
#(
  parameter int LANES = 3,
  parameter logic [ADDR_W-1:0] GPEN_BASE = 8'h60,
  parameter logic [ADDR_W-1:0] ARR_BASE  = 8'h64,
  parameter int ARR_STEP = 4,
  parameter int ARR_COUNT = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wr_byte,
  output logic              rd_hit,
  output logic [BYTE_W-1:0] rd_byte
);
  localparam int GPEN_LANES = 2;
  localparam int ARR_W = LANES * BYTE_W;

  logic [GPEN_LANES*BYTE_W-1:0] gpen_vec;
  logic [ARR_W-1:0]             arr_vec [ARR_COUNT];
  logic [ARR_COUNT-1:0]         arr_hit;
  logic [BYTE_W-1:0]            arr_byte [ARR_COUNT];

  gpo_byte_bank #(.LANES(GPEN_LANES), .BASE(GPEN_BASE)) u_gpen (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(addr),
    .wr_byte(wr_byte), .vec_q(gpen_vec)
  );

  genvar g;
  generate
    for (g = 0; g < ARR_COUNT; g++) begin : g_arr
      localparam logic [ADDR_W-1:0] GB = ARR_BASE + ADDR_W'(g * ARR_STEP);
      gpo_byte_bank #(.LANES(LANES), .BASE(GB)) u_bank (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(addr),
        .wr_byte(wr_byte), .vec_q(arr_vec[g])
      );
      assign arr_hit[g]  = in_window(addr, GB, LANES);
      assign arr_byte[g] = pick_byte(PICK_W'(arr_vec[g]), int'(addr - GB));
    end
  endgenerate

  always_comb begin
    rd_hit  = 1'b0;
    rd_byte = '0;
    if (in_window(addr, GPEN_BASE, GPEN_LANES)) begin
      rd_hit  = 1'b1;
      rd_byte = pick_byte(PICK_W'(gpen_vec), int'(addr - GPEN_BASE));
    end
    for (int i = 0; i < ARR_COUNT; i++) begin
      if (arr_hit[i]) begin
        rd_hit  = 1'b1;
        rd_byte = arr_byte[i];
      end
    end
  end
endmodule

// File: rtl/gpo_notify_port.sv
module gpo_notify_port
  import gpo_pkg::*;
#(
  parameter int LANES = 3,
  parameter logic [ADDR_W-1:0] DATA_BASE = 8'h78,
  parameter logic [ADDR_W-1:0] OE_BASE   = 8'h7C
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    bus_wr,
  input  logic [ADDR_W-1:0]       bus_addr,
  input  logic [BYTE_W-1:0]       bus_wdata,
  output logic [BYTE_W-1:0]       bus_rdata,
  output logic [LANES*BYTE_W-1:0] pin_level,
  output logic [LANES*BYTE_W-1:0] pin_chg
);
  localparam int PINS = LANES * BYTE_W;

  logic [PINS-1:0]   data_vec;
  logic [PINS-1:0]   oe_vec;
  logic [PINS-1:0]   eff_level;
  logic              data_sel;
  logic              oe_sel;
  logic              aux_hit;
  logic [BYTE_W-1:0] aux_byte;
  logic [PICK_W-1:0] gated_wide;

  gpo_byte_bank #(.LANES(LANES), .BASE(DATA_BASE)) u_data (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_addr(bus_addr),
    .wr_byte(bus_wdata), .vec_q(data_vec)
  );

  gpo_byte_bank #(.LANES(LANES), .BASE(OE_BASE)) u_oe (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .wr_addr(bus_addr),
    .wr_byte(bus_wdata), .vec_q(oe_vec)
  );

  assign gated_wide = gate_level(PICK_W'(data_vec), PICK_W'(oe_vec));
  assign eff_level  = gated_wide[PINS-1:0];

  gpo_change_track #(.W(PINS)) u_track (
    .clk(clk), .rst_n(rst_n), .eff_level(eff_level),
    .level_q(pin_level), .chg_q(pin_chg)
  );

  gpo_aux_store #(.LANES(LANES)) u_aux (
    .clk(clk), .rst_n(rst_n), .wr_en(bus_wr), .addr(bus_addr),
    .wr_byte(bus_wdata), .rd_hit(aux_hit), .rd_byte(aux_byte)
  );

  assign data_sel = in_window(bus_addr, DATA_BASE, LANES);
  assign oe_sel   = in_window(bus_addr, OE_BASE, LANES);

  always_comb begin
    if (data_sel)     bus_rdata = pick_byte(PICK_W'(data_vec), int'(bus_addr - DATA_BASE));
    else if (oe_sel)  bus_rdata = pick_byte(PICK_W'(oe_vec), int'(bus_addr - OE_BASE));
    else if (aux_hit) bus_rdata = aux_byte;
    else              bus_rdata = '0;
  end
endmodule

// File: rtl/gpo_notify_chk.sv
module gpo_notify_chk #(
  parameter int PINS = 24
) (
  input logic            clk,
  input logic            rst_n,
  input logic            bus_wr,
  input logic [PINS-1:0] data_vec,
  input logic [PINS-1:0] oe_vec,
  input logic [PINS-1:0] pin_level,
  input logic [PINS-1:0] pin_chg
);
  AST_RESET_QUIET: assert property (@(posedge clk)
    !rst_n |=> (pin_level == '0 && pin_chg == '0 && data_vec == '0 && oe_vec == '0)); // R1

  AST_DATA_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(data_vec)); // R2

  AST_OE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_wr |=> $stable(oe_vec)); // R3

  AST_LEVEL_GATED: assert property (@(posedge clk) disable iff (!rst_n)
    pin_level == $past(data_vec & oe_vec)); // R4

  AST_STROBE_IS_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    pin_chg == (pin_level ^ $past(pin_level))); // R5

  AST_STROBE_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (pin_chg != '0) |-> $past(bus_wr, 2)); // R6
endmodule

bind gpo_notify_port gpo_notify_chk #(.PINS(LANES * 8)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .data_vec(data_vec),
  .oe_vec(oe_vec), .pin_level(pin_level), .pin_chg(pin_chg)
);

// File: tb/gpo_notify_port_bench.sv
`timescale 1ns/1ps
module gpo_notify_port_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [7:0]  bus_addr = 8'h00;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [23:0] pin_level;
  logic [23:0] pin_chg;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #2 clk = ~clk; // 250 MHz

  gpo_notify_port u_gpo_notify_port (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pin_level(pin_level), .pin_chg(pin_chg)
  );

  // ---------------- behavioural reference ----------------
  logic [7:0]  m_mem [256];
  logic [23:0] m_level;
  logic [23:0] m_chg;

  function automatic bit mapped(input int a);
    return (a == 'h60) || (a == 'h61) ||
           (a >= 'h64 && a <= 'h66) || (a >= 'h68 && a <= 'h6a) ||
           (a >= 'h6c && a <= 'h6e) || (a >= 'h70 && a <= 'h72) ||
           (a >= 'h78 && a <= 'h7a) || (a >= 'h7c && a <= 'h7e);
  endfunction

  function automatic logic [23:0] model_eff();
    logic [23:0] e;
    for (int i = 0; i < 3; i++) e[i*8 +: 8] = m_mem['h78 + i] & m_mem['h7c + i];
    return e;
  endfunction

  function automatic logic [7:0] model_read(input int a);
    return mapped(a) ? m_mem[a] : 8'h00;
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) m_mem[i] = 8'h00;
      m_level = '0;
      m_chg   = '0;
    end else begin
      logic [23:0] e;
      e = model_eff();
      m_chg   = e ^ m_level;
      m_level = e;
      if (bus_wr && mapped(int'(bus_addr))) m_mem[bus_addr] = bus_wdata;
    end
  end

  // per-clock comparison of the pins (R4, R5)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      checks++;
      if (pin_level !== m_level) begin
        fails++;
        $display("FAIL R4 pin_level actual=%06h expected=%06h", pin_level, m_level);
      end
      checks++;
      if (pin_chg !== m_chg) begin
        fails++;
        $display("FAIL R5 pin_chg actual=%06h expected=%06h", pin_chg, m_chg);
      end
    end
  end

  // ---------------- helpers ----------------
  task automatic check24(input string req, input logic [23:0] act, input logic [23:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%06h expected=%06h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd_check(input string req, input logic [7:0] a, input logic [7:0] exp);
    @(negedge clk);
    bus_addr = a;
    #1;
    checks++;
    if (bus_rdata !== exp) begin
      fails++;
      $display("FAIL %s read %02h actual=%02h expected=%02h", req, a, bus_rdata, exp);
    end
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // ---------------- watchdog ----------------
  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  // ---------------- stimulus ----------------
  initial begin
    logic [31:0] lfsr;
    idle(3);
    #1;
    // R1: reset state
    check24("R1 level in reset", pin_level, 24'h0);
    check24("R1 chg in reset", pin_chg, 24'h0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(2);
    #1;
    check24("R1 level after reset", pin_level, 24'h0);
    check24("R1 chg after reset", pin_chg, 24'h0);
    rd_check("R1 data byte", 8'h78, 8'h00);
    rd_check("R1 enable byte", 8'h7c, 8'h00);

    // R6: data change with enable 0 gives nothing
    wr(8'h78, 8'hA5);
    idle(1); #1;
    check24("R6 masked data level", pin_level, 24'h0);
    check24("R6 masked data chg", pin_chg, 24'h0);

    // R4/R5: open lane 0 enables
    wr(8'h7c, 8'h0F);
    @(negedge clk); #1;
    check24("R4 gated level", pin_level, 24'h000005);
    check24("R5 rising strobe", pin_chg, 24'h000005);
    @(negedge clk); #1;
    check24("R5 strobe single cycle", pin_chg, 24'h0);

    // R2: lane isolation on data
    wr(8'h79, 8'h3C);
    wr(8'h7a, 8'hC3);
    rd_check("R2 lane0 kept", 8'h78, 8'hA5);
    rd_check("R2 lane1", 8'h79, 8'h3C);
    rd_check("R2 lane2", 8'h7a, 8'hC3);

    // R3: lane isolation on enable
    wr(8'h7d, 8'hFF);
    wr(8'h7e, 8'h0F);
    rd_check("R3 lane0 kept", 8'h7c, 8'h0F);
    rd_check("R3 lane1", 8'h7d, 8'hFF);
    rd_check("R3 lane2", 8'h7e, 8'h0F);
    idle(1); #1;
    check24("R4 three lanes", pin_level, 24'h033C05);

    // R6: same-value rewrite
    wr(8'h7d, 8'hFF);
    @(negedge clk); #1;
    check24("R6 rewrite chg", pin_chg, 24'h0);
    check24("R6 rewrite level", pin_level, 24'h033C05);

    // R5: falling strobes when lane 1 enables close
    wr(8'h7d, 8'h00);
    @(negedge clk); #1;
    check24("R5 falling strobe", pin_chg, 24'h003C00);
    check24("R4 closed lane", pin_level, 24'h030005);

    // R7: storage bytes read back and leave pins alone
    for (int a = 'h60; a <= 'h72; a++) begin
      if (mapped(a)) wr(8'(a), 8'(a ^ 'h5A));
    end
    idle(1); #1;
    check24("R7 pins untouched", pin_level, 24'h030005);
    check24("R7 no strobe", pin_chg, 24'h0);
    rd_check("R7 gp enable hi", 8'h61, 8'h61 ^ 8'h5A);
    rd_check("R7 status", 8'h65, 8'h65 ^ 8'h5A);
    rd_check("R7 mask", 8'h6a, 8'h6a ^ 8'h5A);
    rd_check("R7 edge", 8'h6c, 8'h6c ^ 8'h5A);
    rd_check("R7 invert", 8'h72, 8'h72 ^ 8'h5A);

    // R8: unmapped addresses
    wr(8'h7b, 8'hFF);
    wr(8'h7f, 8'hFF);
    wr(8'h00, 8'hFF);
    idle(1); #1;
    check24("R8 pins after unmapped writes", pin_level, 24'h030005);
    rd_check("R8 gap 7b", 8'h7b, 8'h00);
    rd_check("R8 gap 7f", 8'h7f, 8'h00);
    rd_check("R8 zero", 8'h00, 8'h00);
    rd_check("R8 hole 63", 8'h63, 8'h00);

    // pseudo-random stream against the model (R2-R8)
    lfsr = 32'h1ACE_B00C;
    for (int n = 0; n < 3000; n++) begin
      int a;
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      case (lfsr[3:0])
        4'd0, 4'd1, 4'd2, 4'd3, 4'd4, 4'd5: a = 'h78 + (lfsr[9:8] % 3);
        4'd6, 4'd7, 4'd8, 4'd9, 4'd10:      a = 'h7c + (lfsr[9:8] % 3);
        4'd11, 4'd12:                       a = 'h60 + lfsr[12:8];
        default:                            a = int'(lfsr[23:16]);
      endcase
      if (lfsr[4]) begin
        wr(8'(a), lfsr[31:24]);
      end else begin
        rd_check("R2/R3/R7/R8 random read", 8'(a), model_read(a));
      end
    end
    idle(3);

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule